// File: doc/BRIEF.md
# Reshapeable Synchronous Block RAM

A 2048-bit synchronous memory whose word shape is picked by a mode input: 256 words of 8 bits, 512 of 4, 1024 of 2 or 2048 of 1. The storage is one physical array of 256 rows of 8 bits. In the narrower shapes the address bits above the 8-bit row index pick which lane of the row is read or written. A write changes only that lane. There is one write port and one read port. Both can be used in the same cycle.

The request side and the data output side each have a register that a static input turns on or off. This lets the block trade read latency for timing slack. The top module puts `GANG` such blocks side by side, with a default of two. The gang shares one address and one set of controls. Each block holds its own slice of the word, so the word width doubles in every shape. For example, the x8 shape becomes 256x16.

Top module: `shape_ram`

## Requirements
- R1: `mode_i` selects the shape of each block: 0 is 256x8, 1 is 512x4, 2 is 1024x2 and 3 is 2048x1. The word width is GANG times the block lane width W (W = 8 >> mode_i). Block g holds word bits [g*W +: W].
- R2: The row is `addr[7:0]`. The lane index is the lowest mode_i bits of `addr[10:8]`, and the lane covers row bits [index*W +: W]. Address bits of `addr[10:8]` above the lane index are ignored.
- R3: A write replaces only the addressed lane. The other lanes of the row keep their values.
- R4: A read issued in cycle t appears on `rdata_o` after 1 + in_reg_en_i + out_reg_en_i rising edges.
- R5: A read and a write to the same location in the same cycle return the data held before that write.
- R6: `rdata_o` bits at and above GANG*W are zero.
- R7: When no read is issued, `rdata_o` holds the data of the last read.
- R8: Reset clears the pipeline so that `rdata_o` is zero. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Shape select (0 x8, 1 x4, 2 x2, 3 x1), static during operation |
| in_reg_en_i | input | 1 | Enables the request-side register |
| out_reg_en_i | input | 1 | Enables the output register |
| we_i | input | 1 | Write enable |
| waddr_i | input | 11 | Write address |
| wdata_i | input | 16 | Write data, low GANG*W bits used |
| re_i | input | 1 | Read enable |
| raddr_i | input | 11 | Read address |
| rdata_o | output | 16 | Read data, zero-extended |

## Verification
If a lane mask is wrong, the damage stays hidden until another lane of that row is read. The bench therefore reads rows at full width after narrow writes, which shows it in the read that follows. An error in the offset or the slicing gives a bad word on the first read of any lane other than lane 0. A pipeline register that is missing or extra puts the correct data one cycle early or late, so every read in that configuration fails. A hold error shows on the first idle cycle.

// File: rtl/shape_ram_pkg.sv
package shape_ram_pkg;
  localparam int PHYS_W    = 8;
  localparam int ROW_BITS  = 8;
  localparam int LANE_BITS = $clog2(PHYS_W);
  localparam int ADDR_W    = ROW_BITS + LANE_BITS;

  typedef enum logic [1:0] {
    SHAPE_X8 = 2'd0,
    SHAPE_X4 = 2'd1,
    SHAPE_X2 = 2'd2,
    SHAPE_X1 = 2'd3
  } shape_e;

  function automatic int lane_width(shape_e s);
    return PHYS_W >> s;
  endfunction

  function automatic logic [PHYS_W-1:0] lane_mask(shape_e s);
    return {PHYS_W{1'b1}} >> (PHYS_W - lane_width(s));
  endfunction

  // bit offset of the addressed lane inside the physical row
  function automatic logic [LANE_BITS-1:0] lane_offset(shape_e s, logic [ADDR_W-1:0] a);
    logic [LANE_BITS-1:0] sel;
    logic [LANE_BITS-1:0] keep;
    sel  = a[ROW_BITS +: LANE_BITS];
    keep = LANE_BITS'((1 << s) - 1);
    return LANE_BITS'(int'(sel & keep) * lane_width(s));
  endfunction
endpackage

// File: rtl/shape_ram_instage.sv
module shape_ram_instage
  import shape_ram_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o
);
  localparam int PW = 2 + 2 * ADDR_W + DW;

  logic [PW-1:0] req_d, req_q, req_s;

  assign req_d = {we_i, re_i, waddr_i, raddr_i, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_s = en_i ? req_q : req_d;
  assign {we_o, re_o, waddr_o, raddr_o, wdata_o} = req_s;

  // R4
  in_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(rst_ni)) |-> (req_s == $past(req_d)));
endmodule

// File: rtl/shape_ram_array.sv
module shape_ram_array
  import shape_ram_pkg::*;
#(
  parameter int ROWS = 1 << ROW_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  shape_e            mode_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [PHYS_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [PHYS_W-1:0]    rd_row_o,
  output logic [LANE_BITS-1:0] rd_off_o
);
  localparam int RAW = $clog2(ROWS);

  logic [PHYS_W-1:0] mem [ROWS];
  logic [RAW-1:0]    wrow, rrow;
  logic [PHYS_W-1:0] lmask, wmask, wlane;
  logic [LANE_BITS-1:0] woff;

  assign wrow  = waddr_i[RAW-1:0];
  assign rrow  = raddr_i[RAW-1:0];
  assign woff  = lane_offset(mode_i, waddr_i);
  assign lmask = lane_mask(mode_i);
  assign wmask = lmask << woff;
  assign wlane = (wdata_i & lmask) << woff;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wrow] <= (mem[wrow] & ~wmask) | wlane;
  end

  // nonblocking read: same-cycle write is not visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_row_o <= '0;
      rd_off_o <= '0;
    end else if (re_i) begin
      rd_row_o <= mem[rrow];
      rd_off_o <= lane_offset(mode_i, raddr_i);
    end
  end

  // R3
  lane_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem[$past(wrow)] & ~$past(wmask)) == ($past(mem[wrow]) & ~$past(wmask))));

  // R5
  old_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && we_i && (rrow == wrow)) |=> (rd_row_o == $past(mem[rrow])));

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!re_i && $past(rst_ni)) |=> $stable(rd_row_o));
endmodule

// File: rtl/shape_ram_outstage.sv
module shape_ram_outstage
  import shape_ram_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  shape_e               mode_i,
  input  logic                 en_i,
  input  logic [PHYS_W-1:0]    row_i,
  input  logic [LANE_BITS-1:0] off_i,
  output logic [PHYS_W-1:0]    data_o
);
  logic [PHYS_W-1:0] ext, data_q;

  assign ext = (row_i >> off_i) & lane_mask(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= ext;
  end

  assign data_o = en_i ? data_q : ext;

  // R4
  out_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(rst_ni)) |-> (data_o == $past(ext)));
endmodule

// File: rtl/shape_ram.sv
module shape_ram
  import shape_ram_pkg::*;
#(
  parameter int GANG = 2,
  localparam int DW  = GANG * PHYS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              in_reg_en_i,
  input  logic              out_reg_en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o
);
  shape_e            mode;
  int                lw;
  logic              s_we, s_re;
  logic [ADDR_W-1:0] s_waddr, s_raddr;
  logic [DW-1:0]     s_wdata;
  logic [PHYS_W-1:0] blk_wd [GANG];
  logic [PHYS_W-1:0] blk_rd [GANG];
  logic [PHYS_W-1:0] blk_row [GANG];
  logic [LANE_BITS-1:0] blk_off [GANG];

  assign mode = shape_e'(mode_i);
  assign lw   = lane_width(mode);

  shape_ram_instage #(.DW(DW)) u_in (
    .clk_i, .rst_ni, .en_i(in_reg_en_i),
    .we_i, .waddr_i, .wdata_i, .re_i, .raddr_i,
    .we_o(s_we), .waddr_o(s_waddr), .wdata_o(s_wdata),
    .re_o(s_re), .raddr_o(s_raddr)
  );

  for (genvar g = 0; g < GANG; g++) begin : g_blk
    assign blk_wd[g] = PHYS_W'(s_wdata >> (g * lw));

    shape_ram_array u_arr (
      .clk_i, .rst_ni, .mode_i(mode),
      .we_i(s_we), .waddr_i(s_waddr), .wdata_i(blk_wd[g]),
      .re_i(s_re), .raddr_i(s_raddr),
      .rd_row_o(blk_row[g]), .rd_off_o(blk_off[g])
    );

    shape_ram_outstage u_out (
      .clk_i, .rst_ni, .mode_i(mode), .en_i(out_reg_en_i),
      .row_i(blk_row[g]), .off_i(blk_off[g]), .data_o(blk_rd[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int g = 0; g < GANG; g++) rdata_o = rdata_o | (DW'(blk_rd[g]) << (g * lw));
  end

  // R6
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rdata_o >> (GANG * lw)) == '0));
endmodule

// File: tb/shape_ram_test.sv
module shape_ram_test;
  localparam int CLK_PERIOD = 10;
  localparam int GANG = 2;
  localparam int DW = GANG * 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode = '0;
  logic in_en = 1'b0, out_en = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [10:0] waddr = '0, raddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] mdl [GANG][256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  shape_ram #(.GANG(GANG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .in_reg_en_i(in_en), .out_reg_en_i(out_en),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .re_i(re), .raddr_i(raddr), .rdata_o(rdata)
  );

  function automatic int lane_off(int m, logic [10:0] a);
    int w = 8 >> m;
    return (int'(a[10:8]) & ((1 << m) - 1)) * w;
  endfunction

  function automatic logic [DW-1:0] model_read(int m, logic [10:0] a);
    logic [DW-1:0] r = '0;
    int w = 8 >> m;
    int off = lane_off(m, a);
    for (int g = 0; g < GANG; g++)
      for (int b = 0; b < w; b++) r[g * w + b] = mdl[g][a[7:0]][off + b];
    return r;
  endfunction

  task automatic model_write(int m, logic [10:0] a, logic [DW-1:0] d);
    int w = 8 >> m;
    int off = lane_off(m, a);
    for (int g = 0; g < GANG; g++)
      for (int b = 0; b < w; b++) mdl[g][a[7:0]][off + b] = d[g * w + b];
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    we = 1'b0; re = 1'b0; waddr = '0; raddr = '0; wdata = '0;
  endtask

  task automatic run_phase(int m, bit inr, bit outr, int n_ops, int wr_pct, int rd_pct,
                           bit same, bit seq, string tag);
    int lat;
    logic [DW-1:0] exp_v;
    logic [DW-1:0] pend_v [512];
    bit pend_f [512];
    lat = 1 + int'(inr) + int'(outr);
    @(negedge clk);
    rst_ni = 1'b0; mode = 2'(m); in_en = inr; out_en = outr;
    drive_idle();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    exp_v = '0;
    for (int n = 0; n < n_ops + lat + 1; n++) begin
      if (n > 0) @(negedge clk);
      if (n >= lat && pend_f[n - lat]) exp_v = pend_v[n - lat];
      chk(n == 0 ? "R8" : tag, rdata, exp_v);
      pend_f[n] = 1'b0;
      if (n < n_ops) begin
        if (seq) begin
          we = 1'b1; re = 1'b0;
          waddr = 11'(n); raddr = '0;
        end else begin
          we = (($urandom % 100) < wr_pct);
          re = (($urandom % 100) < rd_pct);
          waddr = {3'($urandom), 8'($urandom % 16)};
          raddr = {3'($urandom), 8'($urandom % 16)};
          if (same) begin we = 1'b1; re = 1'b1; raddr = waddr; end
        end
        wdata = DW'($urandom);
        if (re) begin pend_f[n] = 1'b1; pend_v[n] = model_read(m, raddr); end
        if (we) model_write(m, waddr, wdata);
      end else begin
        drive_idle();
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    drive_idle();
    // R1 fill rows 0..15 at full width
    run_phase(0, 0, 0, 16, 100, 0, 0, 1, "R1");
    // R8 contents survive the reset between phases
    run_phase(0, 0, 0, 40, 0, 100, 0, 0, "R8");
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        run_phase(m, c[0], c[1], 150, 50, 60, 0, 0,
                  c == 0 ? (m == 3 ? "R6" : "R1") : (c == 3 ? "R2" : "R4"));
    // R3 narrow writes, then full-row reads expose untouched lanes
    run_phase(3, 0, 0, 120, 100, 0, 0, 0, "R3");
    run_phase(0, 0, 1, 60, 0, 100, 0, 0, "R3");
    run_phase(1, 0, 0, 120, 100, 0, 0, 0, "R3");
    run_phase(0, 1, 0, 60, 0, 100, 0, 0, "R3");
    // R5 same-location read and write every cycle
    run_phase(1, 1, 1, 100, 100, 100, 1, 0, "R5");
    run_phase(2, 0, 0, 100, 100, 100, 1, 0, "R5");
    // R7 sparse reads, output must hold between them
    run_phase(2, 0, 1, 150, 40, 10, 0, 0, "R7");
    run_phase(3, 1, 0, 150, 40, 10, 0, 0, "R7");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual cycles=%0d expected fewer", WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule